// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when the chip leaves its two low-power modes, Stop and Sleep, and goes back to Normal. Normal mode leaves on a single-cycle request from the MCU. In Stop the regulator stays up and a wake-up is reported by an interrupt. In Sleep the regulator is off, so a wake-up turns it back on and holds the MCU in reset for a fixed number of cycles.

Four wake sources are watched:

- **Wake input.** A change of the wake input line, seen either at once or only at the end of each cyclic-sense period. During that sense window the selected high-side outputs are pulsed.
- **Forced timer.** A timer that expires after the programmed period.
- **LIN bus.** A long dominant phase on the LIN receive line, ended by a release edge.
- **Chip select.** A rising edge on the active-low chip select, which is honoured in Stop only.

An 8-bit register port holds the enables, the period code, the high-side selection and the LIN dominant threshold. The same port reads back a status word and a clear-on-read cause register. Inputs are taken as already synchronous to `clk`. `lp_tick` is a one-cycle enable from the slow low-power clock.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, `mode` is Normal (0), `irq` and `mcu_rst` are 0 and `reg_en` is 1. In Normal, `go_sleep` moves to Sleep (`mode`=2) at the next edge. `go_stop` alone moves to Stop (`mode`=1). If both are high, Sleep wins.
- R2: In Stop or Sleep, the mode stays put unless an enabled source fires. A disabled source has no effect.
- R3: A wake-up from Stop returns to Normal at the same edge that latches the cause. `irq` is 1 while any bit of the cause register (read address 0) is set.
- R4: In Sleep, `reg_en` is 0. A wake-up from Sleep raises `reg_en` and holds `mcu_rst` high for RST_CYC cycles, starting in the cycle the mode becomes Normal.
- R5: A rising edge on `cs_n` wakes from Stop without setting any cause bit or `irq`. In Sleep, `cs_n` has no effect.
- R6: With the LIN enable (config bit 1) set, a LIN wake fires on a low-to-high edge of `lin_rx`. The preceding low phase must have lasted more than the threshold written to address 3, counted in clock cycles. It sets cause bit 1. A shorter pulse, or a line held low, does not wake.
- R7: With receive-only (config bit 2) set, LIN wake is blocked in Stop but still works in Sleep.
- R8: With the wake-input enable (config bit 0) set and cyclic sense off, any difference between `wake_in` and its level at low-power entry wakes at once and sets cause bit 0.
- R9: With cyclic sense on (address 1 bit 3), the period is BASE_TICKS·2^code `lp_tick`s, where code is address 1 bits 2:0.
  - During the last tick of each period, `hs_on` equals the high-side enable bits (address 2).
  - A change of `wake_in` wakes only at the period end and sets cause bit 0.
- R10: With the forced wake-up (address 1 bit 4) on and all high-side enables clear, the block wakes when the period ends and sets cause bit 2. If any high-side enable is set, the forced wake-up never fires.
- R11: Cyclic and forced enables are never both set. A write to address 1 turns one on only if the other is not already stored. If both are requested while neither is stored, cyclic is taken. Read address 2 returns {forced, cyclic, code} in bits 4:0.
- R12: If the analog-mux select bit (config bit 3) is set when a low-power mode is entered, the wake input cannot cause a wake-up in that stay.
- R13: Reading address 0 returns the cause bits and clears them at the following edge. `irq` stays high until that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_tick | input | 1 | Low-power clock enable for the period timer |
| go_stop | input | 1 | Request to enter Stop |
| go_sleep | input | 1 | Request to enter Sleep |
| wake_in | input | 1 | Wake input line level |
| lin_rx | input | 1 | LIN receive, 0 = dominant |
| cs_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| mode | output | 2 | 0 Normal, 1 Stop, 2 Sleep |
| irq | output | 1 | Wake interrupt |
| reg_en | output | 1 | Regulator enable |
| mcu_rst | output | 1 | MCU reset, active high |
| hs_on | output | NUM_HS | High-side drive during cyclic sense |

## Verification
The hardest cases to reach are the timer-gated ones. A cyclic wake must not fire mid-period even though the input has already changed. A forced wake must stay silent while any high-side enable is set.

To reach them, the bench runs `lp_tick` every cycle with a short base period. It changes `wake_in` right after one period end and checks Stop and `hs_on` cycle by cycle until the next end. It also arms the forced timer once with high-side bits set and once with them clear, and counts out the exact wake edge.

The LIN filter is driven with pulses on both sides of the threshold and with a line held low well past counter saturation.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      LPW_NORMAL = 2'd0,
      LPW_STOP   = 2'd1,
      LPW_SLEEP  = 2'd2
   } lpw_mode_e;

   typedef struct packed {
      logic             amux_wk;
      logic             rx_only;
      logic             lin_en;
      logic             wkin_en;
      logic             frc_en;
      logic             cyc_en;
      logic [2:0]       per_code;
      logic [REG_W-1:0] lin_thr;
   } lpw_cfg_t;

   localparam int CAUSE_W    = 3;
   localparam int CAUSE_WKIN = 0;
   localparam int CAUSE_LIN  = 1;
   localparam int CAUSE_FRC  = 2;
endpackage

// File: rtl/lpw_regs.sv
module lpw_regs
   import lpw_pkg::*;
#(
   parameter int NUM_HS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [1:0]         rd_addr,
   output logic [REG_W-1:0]   rd_data,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic [REG_W-1:0]   status_in,
   output logic [CAUSE_W-1:0] cause,
   output lpw_cfg_t           cfg,
   output logic [NUM_HS-1:0]  hs_en
);
   logic cyc_new, frc_new, clr;

   // exclusivity: stored enable blocks the other; cyclic wins a tie
   assign cyc_new = wr_data[3] & ~cfg.frc_en;
   assign frc_new = wr_data[4] & ~cfg.cyc_en & ~wr_data[3];
   assign clr     = rd_en && (rd_addr == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg   <= '0;
         hs_en <= '0;
         cause <= '0;
      end else begin
         cause <= (clr ? '0 : cause) | cause_set;
         if (wr_en) begin
            unique case (wr_addr)
               2'd0: begin
                  cfg.wkin_en <= wr_data[0];
                  cfg.lin_en  <= wr_data[1];
                  cfg.rx_only <= wr_data[2];
                  cfg.amux_wk <= wr_data[3];
               end
               2'd1: begin
                  cfg.per_code <= wr_data[2:0];
                  cfg.cyc_en   <= cyc_new;
                  cfg.frc_en   <= frc_new;
               end
               2'd2: hs_en <= wr_data[NUM_HS-1:0];
               default: cfg.lin_thr <= wr_data;
            endcase
         end
      end
   end

   always_comb begin
      unique case (rd_addr)
         2'd0: rd_data = REG_W'(cause);
         2'd1: rd_data = status_in;
         2'd2: rd_data = REG_W'({cfg.frc_en, cfg.cyc_en, cfg.per_code});
         default: rd_data = REG_W'({cfg.amux_wk, cfg.rx_only, cfg.lin_en, cfg.wkin_en});
      endcase
   end
endmodule

// File: rtl/lpw_timer.sv
module lpw_timer #(
   parameter int BASE_TICKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       lp_tick,
   input  logic [2:0] code,
   output logic       sense,
   output logic       period_end
);
   localparam int CW = $clog2(BASE_TICKS * 128) + 1;

   logic [CW-1:0] cnt, lim;
   logic          last;

   assign lim        = CW'(BASE_TICKS) << code;
   assign last       = (cnt == lim - CW'(1));
   assign sense      = run & last;
   assign period_end = run & last & lp_tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)   cnt <= '0;
      else if (period_end)  cnt <= '0;
      else if (lp_tick)     cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/lpw_linwake.sv
module lpw_linwake #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lin_rx,
   input  logic [CW-1:0] thr,
   output logic          release_ok
);
   logic [CW-1:0] dom_cnt;
   logic          prev;

   assign release_ok = lin_rx & ~prev & (dom_cnt > thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dom_cnt <= '0;
         prev    <= 1'b1;
      end else begin
         prev <= lin_rx;
         if (lin_rx)              dom_cnt <= '0;
         else if (~&dom_cnt)      dom_cnt <= dom_cnt + CW'(1);
      end
   end
endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
   import lpw_pkg::*;
#(
   parameter int NUM_HS     = 2,
   parameter int BASE_TICKS = 4,
   parameter int RST_CYC    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_tick,
   input  logic              go_stop,
   input  logic              go_sleep,
   input  logic              wake_in,
   input  logic              lin_rx,
   input  logic              cs_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [7:0]        rd_data,
   output logic [1:0]        mode,
   output logic              irq,
   output logic              reg_en,
   output logic              mcu_rst,
   output logic [NUM_HS-1:0] hs_on
);
   localparam int RW = $clog2(RST_CYC + 1);

   if (NUM_HS < 1 || NUM_HS > REG_W) begin : g_bad_hs
      $error("NUM_HS out of range");
   end
   if (BASE_TICKS < 1) begin : g_bad_base
      $error("BASE_TICKS must be positive");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be positive");
   end

   lpw_mode_e          mode_q;
   lpw_cfg_t           cfg;
   logic [NUM_HS-1:0]  hs_en;
   logic [CAUSE_W-1:0] cause, cause_set;
   logic [RW-1:0]      rst_cnt;
   logic wk_ref, wk_mask, cs_prev;
   logic in_lp, cyc_act, frc_act, sense, period_end, lin_rel;
   logic wk_w, lin_w, frc_w, cs_w, wake_any;

   assign in_lp   = (mode_q != LPW_NORMAL);
   assign cyc_act = cfg.cyc_en;
   assign frc_act = cfg.frc_en & ~|hs_en;

   lpw_regs #(.NUM_HS(NUM_HS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cause_set(cause_set),
      .status_in({5'b0, mode_q, wake_in}), .cause(cause), .cfg(cfg), .hs_en(hs_en)
   );

   lpw_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(in_lp & (cfg.cyc_en | cfg.frc_en)),
      .lp_tick(lp_tick), .code(cfg.per_code), .sense(sense), .period_end(period_end)
   );

   lpw_linwake #(.CW(REG_W)) u_lin (
      .clk(clk), .rst_n(rst_n), .lin_rx(lin_rx), .thr(cfg.lin_thr), .release_ok(lin_rel)
   );

   always_comb begin
      wk_w  = in_lp & cfg.wkin_en & ~wk_mask & (wake_in != wk_ref)
              & (~cyc_act | period_end);
      lin_w = in_lp & cfg.lin_en & lin_rel & ~(cfg.rx_only & (mode_q == LPW_STOP));
      frc_w = in_lp & frc_act & period_end;
      cs_w  = (mode_q == LPW_STOP) & cs_n & ~cs_prev;
      wake_any = wk_w | lin_w | frc_w | cs_w;
      cause_set = '0;
      cause_set[CAUSE_WKIN] = wk_w;
      cause_set[CAUSE_LIN]  = lin_w;
      cause_set[CAUSE_FRC]  = frc_w;
   end

   for (genvar i = 0; i < NUM_HS; i++) begin : g_hs
      assign hs_on[i] = sense & cyc_act & hs_en[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= LPW_NORMAL;
         wk_ref  <= 1'b0;
         wk_mask <= 1'b0;
         cs_prev <= 1'b1;
         rst_cnt <= '0;
      end else begin
         cs_prev <= cs_n;
         if (rst_cnt != '0) rst_cnt <= rst_cnt - RW'(1);
         if (!in_lp) begin
            if (go_sleep || go_stop) begin
               mode_q  <= go_sleep ? LPW_SLEEP : LPW_STOP;
               wk_ref  <= wake_in;
               wk_mask <= cfg.amux_wk;
            end
         end else if (wake_any) begin
            if (mode_q == LPW_SLEEP) rst_cnt <= RW'(RST_CYC);
            mode_q <= LPW_NORMAL;
         end else if (period_end) begin
            wk_ref <= wake_in;
         end
      end
   end

   assign mode    = mode_q;
   assign irq     = |cause;
   assign reg_en  = (mode_q != LPW_SLEEP);
   assign mcu_rst = (rst_cnt != '0);
endmodule

// File: rtl/lpw_chk.sv
module lpw_chk #(
   parameter int NUM_HS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              go_stop,
   input logic              go_sleep,
   input logic              irq,
   input logic              rd_en,
   input logic [1:0]        rd_addr,
   input logic              reg_en,
   input logic              mcu_rst,
   input logic [NUM_HS-1:0] hs_on,
   input logic              cyc_en,
   input logic              frc_en
);
   a_r1_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && go_stop && !go_sleep) |=> (mode == 2'd1));
   a_r1_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && go_sleep) |=> (mode == 2'd2));
   a_r4_regulator_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> !reg_en);
   a_r4_reset_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |=> (mode == 2'd2 || mcu_rst));
   a_r13_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(rd_en && rd_addr == 2'd0)) |=> irq);
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cyc_en && frc_en));
   a_r9_hs_only_sensing: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_on != '0) |-> (mode != 2'd0 && cyc_en));
endmodule

bind lpwake_ctrl lpw_chk #(.NUM_HS(NUM_HS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .go_stop(go_stop), .go_sleep(go_sleep),
   .irq(irq), .rd_en(rd_en), .rd_addr(rd_addr), .reg_en(reg_en), .mcu_rst(mcu_rst),
   .hs_on(hs_on), .cyc_en(cyc_act), .frc_en(frc_act)
);

// File: tb/tb_lpwake_ctrl.sv
`timescale 1ns/1ps
module tb_lpwake_ctrl;
   localparam int NHS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lp_tick = 1'b1, go_stop = 1'b0, go_sleep = 1'b0;
   logic wake_in = 1'b0, lin_rx = 1'b1, cs_n = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic [1:0] mode;
   logic irq, reg_en, mcu_rst;
   logic [NHS-1:0] hs_on;

   always #4 clk = ~clk;

   lpwake_ctrl #(.NUM_HS(NHS), .BASE_TICKS(4), .RST_CYC(3)) dut (
      .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .go_stop(go_stop), .go_sleep(go_sleep),
      .wake_in(wake_in), .lin_rx(lin_rx), .cs_n(cs_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode),
      .irq(irq), .reg_en(reg_en), .mcu_rst(mcu_rst), .hs_on(hs_on)
   );

   typedef struct {
      int    at;
      int    sel;
      int    exp;
      string req;
   } item_t;

   item_t q[$];
   int cyc = 0, checks = 0, errors = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int observe(int sel);
      case (sel)
         0: return int'(mode);
         1: return int'(irq);
         2: return int'(reg_en);
         3: return int'(mcu_rst);
         4: return int'(hs_on);
         default: return int'(rd_data);
      endcase
   endfunction

   // monitor: pop due expectations and compare against the ports
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
         item_t it;
         int act;
         it  = q.pop_front();
         act = observe(it.sel);
         checks++;
         if (act != it.exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%0h expected=%0h cycle=%0d",
                     it.req, it.sel, act, it.exp, cyc);
         end
      end
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic push(int sel, int exp, string req);
      item_t it;
      it.at = cyc; it.sel = sel; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, int exp, string req);
      rd_en = 1'b1; rd_addr = a;
      push(5, exp, req);
      step();
      rd_en = 1'b0;
   endtask

   task automatic enter_stop();
      go_stop = 1'b1; step(); go_stop = 1'b0;
   endtask

   task automatic enter_sleep();
      go_sleep = 1'b1; step(); go_sleep = 1'b0;
   endtask

   task automatic cs_pulse();
      cs_n = 1'b0; step(); cs_n = 1'b1; step();
   endtask

   task automatic lin_pulse(int n);
      lin_rx = 1'b0;
      repeat (n) step();
      lin_rx = 1'b1;
      step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      push(0, 0, "R1 reset mode"); push(1, 0, "R1 reset irq");
      push(2, 1, "R1 reset reg_en"); push(3, 0, "R1 reset mcu_rst");

      // R8 direct wake input, R3 interrupt, R13 clear on read
      wr(2'd0, 8'h01);
      enter_stop();
      push(0, 1, "R1 stop entry");
      step();
      push(0, 1, "R2 stop held");
      wake_in = 1'b1; step();
      push(0, 0, "R8 direct wake"); push(1, 1, "R3 irq on stop wake");
      step();
      push(1, 1, "R13 irq held until read");
      rd(2'd0, 8'h01, "R8 cause wake input");
      push(1, 0, "R13 irq cleared by read");
      rd(2'd0, 8'h00, "R13 cause cleared");

      // R12 mux select masks wake input, R5 silent chip-select wake
      wr(2'd0, 8'h09);
      enter_stop();
      wake_in = 1'b0; step(); step();
      push(0, 1, "R12 masked input ignored");
      cs_pulse();
      push(0, 0, "R5 cs wake from stop"); push(1, 0, "R5 cs no irq");
      rd(2'd0, 8'h00, "R5 cs no cause");

      // R6 LIN wake filter
      wr(2'd0, 8'h02); wr(2'd3, 8'd4);
      enter_stop();
      lin_pulse(3);
      push(0, 1, "R6 short dominant ignored");
      lin_pulse(6);
      push(0, 0, "R6 long dominant wakes");
      rd(2'd0, 8'h02, "R6 cause lin");
      enter_stop();
      lin_rx = 1'b0;
      repeat (300) step();
      push(0, 1, "R6 stuck dominant no wake");
      cs_pulse();
      lin_rx = 1'b1; step();
      push(0, 0, "R6 release in normal"); push(1, 0, "R6 no cause in normal");

      // R7 receive-only, R2 disabled input, R4 sleep wake
      wr(2'd0, 8'h06);
      enter_stop();
      wake_in = 1'b1; step();
      push(0, 1, "R2 disabled wake input");
      lin_pulse(6);
      push(0, 1, "R7 rx-only blocks stop");
      cs_pulse();
      enter_sleep();
      push(0, 2, "R1 sleep entry"); push(2, 0, "R4 regulator off");
      cs_pulse();
      push(0, 2, "R5 cs ignored in sleep");
      lin_pulse(6);
      push(0, 0, "R7 lin wakes sleep"); push(2, 1, "R4 regulator on");
      push(3, 1, "R4 reset asserted");
      step(); step();
      push(3, 1, "R4 reset third cycle");
      step();
      push(3, 0, "R4 reset released");
      rd(2'd0, 8'h02, "R7 cause lin from sleep");

      // R9 cyclic sense
      wr(2'd0, 8'h01); wr(2'd2, 8'h03); wr(2'd1, 8'h08);
      wake_in = 1'b0; step();
      enter_stop();
      step(); step(); step();
      push(4, 3, "R9 hs on in sense"); push(0, 1, "R9 stop held");
      step();
      wake_in = 1'b1;
      push(4, 0, "R9 hs off outside sense");
      step();
      push(0, 1, "R9 no wake mid period");
      step(); step();
      push(0, 1, "R9 no wake before end"); push(4, 3, "R9 hs second sense");
      step();
      push(0, 0, "R9 wake at period end"); push(1, 1, "R9 irq");
      rd(2'd0, 8'h01, "R9 cause wake input");

      // R11 exclusivity
      wr(2'd1, 8'h10);
      rd(2'd2, 8'h00, "R11 forced blocked by cyclic");
      wr(2'd1, 8'h18);
      rd(2'd2, 8'h08, "R11 cyclic wins tie");
      wr(2'd1, 8'h00);
      wr(2'd1, 8'h11);
      rd(2'd2, 8'h11, "R11 forced accepted");

      // R10 forced wake
      enter_stop();
      repeat (20) step();
      push(0, 1, "R10 hs set blocks forced");
      cs_pulse();
      wr(2'd2, 8'h00);
      enter_stop();
      repeat (7) step();
      push(0, 1, "R10 before expiry");
      step();
      push(0, 0, "R10 forced wake"); push(1, 1, "R10 irq");
      rd(2'd0, 8'h04, "R10 cause forced");

      step(); step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule